// File: doc/BRIEF.md
# Track Format Byte Stream Encoder

This block drives the byte stream of a floppy controller's format-a-track command. The host feeds bytes one at a time through a data-register handshake. The block hands each byte to a downstream FM/MFM serializer as a byte value plus a flag. The flag marks a byte that must be written with a missing clock.

Two host byte values act as control codes and are never written as they are:
- F5 becomes a sync byte and restarts the running CRC.
- F7 expands into the two bytes of the CRC gathered since the last sync byte.

All other values pass through unchanged and feed the CRC, including the address marks FE, FB and F8. Writing opens on the first index pulse after the command starts and closes on the next one.

The serializer asks for each byte with a one-cycle slot strobe. A data request tells the host when the holding register is empty. When a slot arrives and no byte is waiting, the block writes 00 and latches a lost-data flag.

Top module: `fmt_stream_enc`

## Requirements
- R1: After reset, busy, drq, lost and out_valid are all low.
- R2: A start pulse while idle raises busy and drq on the next cycle and clears lost. A host write while idle is ignored. A start pulse while busy has no effect.
- R3: After start, no byte is emitted until the first rising edge of index_in. Slot strobes before that edge produce no out_valid and consume no host byte.
- R4: While writing, each slot strobe gives a one-cycle out_valid in the following cycle. A host byte other than F5 or F7 appears unchanged on out_byte with out_mark low.
- R5: Host byte F5 is emitted as A1 with out_mark high. It presets the CRC to the value that results from feeding three A1 bytes into a register that starts at FFFF.
- R6: Host byte F7 takes two slots. The first emits the CRC high byte and the second emits the CRC low byte. The second slot consumes no host byte.
- R7: The CRC uses polynomial x^16+x^12+x^5+1 (0x1021), processed MSB first. It covers every byte emitted after the last sync byte, including the FE, FB and F8 mark values.
- R8: drq is high exactly while busy and no host byte is held. It drops the cycle after a host write and rises the cycle after a slot consumes the held byte.
- R9: A slot that finds no held byte emits 00 with out_mark low and sets lost. lost stays set until the next start.
- R10: The second rising edge of index_in ends the command. busy and drq fall and later slots produce no out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a format command |
| index_in | input | 1 | Index pulse from the drive |
| byte_tick | input | 1 | Byte slot strobe from the serializer |
| host_wr | input | 1 | Host write to the data register |
| host_data | input | 8 | Host data byte |
| busy | output | 1 | Command in progress |
| drq | output | 1 | Data request: holding register empty |
| lost | output | 1 | A slot found no byte waiting |
| out_valid | output | 1 | out_byte and out_mark valid this cycle |
| out_byte | output | 8 | Byte to serialize |
| out_mark | output | 1 | Write this byte with a missing clock |

## Verification
A CRC register that drifts from the expected value shows nothing while data passes through. It becomes visible only at the next F7, as wrong CRC bytes on out_byte. The bench therefore closes every field with F7 and compares both bytes against an independent model.

A lost low-byte-pending bit would show on the slot right after the CRC high byte, as a swallowed host byte or a stray extra byte. A wrong holding-register flag shows at once on drq, or one slot later as a false 00 with lost set.

// File: rtl/fmt_stream_enc.sv
module fmt_stream_enc #(
  parameter logic [7:0]  SYNC_CODE = 8'hF5,
  parameter logic [7:0]  CRC_CODE  = 8'hF7,
  parameter logic [7:0]  SYNC_BYTE = 8'hA1,
  parameter logic [7:0]  FILL_BYTE = 8'h00,
  parameter logic [15:0] CRC_POLY  = 16'h1021,
  parameter logic [15:0] CRC_INIT  = 16'hFFFF,
  parameter int          SYNC_RUN  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       index_in,
  input  logic       byte_tick,
  input  logic       host_wr,
  input  logic [7:0] host_data,
  output logic       busy,
  output logic       drq,
  output logic       lost,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       out_mark
);

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = {r[14:0], 1'b0} ^ ((r[15] ^ b[i]) ? CRC_POLY : 16'h0000);
    return r;
  endfunction

  function automatic logic [15:0] crc_after_sync();
    logic [15:0] r;
    r = CRC_INIT;
    for (int i = 0; i < SYNC_RUN; i++) r = crc_step(r, SYNC_BYTE);
    return r;
  endfunction

  localparam logic [15:0] SYNC_CRC = crc_after_sync();

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_WRITE} st_t;

  st_t         st;
  logic        idx_q, full, lo_pend;
  logic [7:0]  hold;
  logic [15:0] crc;

  wire       idx_rise = index_in & ~idx_q;
  wire [7:0] cur      = full ? hold : FILL_BYTE;

  assign busy = (st != S_IDLE);
  assign drq  = busy & ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx_q     <= 1'b0;
      full      <= 1'b0;
      lo_pend   <= 1'b0;
      hold      <= 8'h00;
      crc       <= CRC_INIT;
      lost      <= 1'b0;
      out_valid <= 1'b0;
      out_byte  <= 8'h00;
      out_mark  <= 1'b0;
    end else begin
      idx_q     <= index_in;
      out_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st      <= S_ARMED;
          full    <= 1'b0;
          lost    <= 1'b0;
          lo_pend <= 1'b0;
          crc     <= CRC_INIT;
        end
        S_ARMED: if (idx_rise) st <= S_WRITE;
        S_WRITE: begin
          if (idx_rise) begin
            st      <= S_IDLE;
            lo_pend <= 1'b0;
          end else if (byte_tick) begin
            out_valid <= 1'b1;
            if (lo_pend) begin
              out_byte <= crc[7:0];
              out_mark <= 1'b0;
              lo_pend  <= 1'b0;
            end else begin
              full <= 1'b0;
              if (!full) lost <= 1'b1;
              if (cur == SYNC_CODE) begin
                out_byte <= SYNC_BYTE;
                out_mark <= 1'b1;
                crc      <= SYNC_CRC;
              end else if (cur == CRC_CODE) begin
                out_byte <= crc[15:8];
                out_mark <= 1'b0;
                lo_pend  <= 1'b1;
              end else begin
                out_byte <= cur;
                out_mark <= 1'b0;
                crc      <= crc_step(crc, cur);
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
      if (host_wr && st != S_IDLE) begin
        hold <= host_data;
        full <= 1'b1;
      end
    end
  end

  p_drq_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> drq);

  p_armed_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARMED) |=> !out_valid);

  p_mark_is_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mark) |-> (out_byte == SYNC_BYTE));

  p_crc_lo_no_consume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WRITE && lo_pend && byte_tick && !idx_rise && full && !host_wr) |=> full);

  p_write_clears_drq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr) |=> !drq);

  p_lost_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && !(st == S_IDLE && start)) |=> lost);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !out_valid);

endmodule

// File: tb/fmt_stream_enc_test.sv
module fmt_stream_enc_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, index_in = 1'b0;
  logic byte_tick = 1'b0, host_wr = 1'b0;
  logic [7:0] host_data = 8'h00;
  logic busy, drq, lost, out_valid, out_mark;
  logic [7:0] out_byte;
  int checks = 0, fails = 0;
  logic [15:0] mcrc;

  always #2.5 clk = ~clk;

  fmt_stream_enc uut (.clk(clk), .rst_n(rst_n), .start(start), .index_in(index_in),
    .byte_tick(byte_tick), .host_wr(host_wr), .host_data(host_data), .busy(busy),
    .drq(drq), .lost(lost), .out_valid(out_valid), .out_byte(out_byte), .out_mark(out_mark));

  function automatic logic [15:0] mstep(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[15] ^ b[7-i]) r = (r << 1) ^ 16'h1021;
      else r = r << 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); host_wr = 1'b1; host_data = b;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); byte_tick = 1'b1;
    @(negedge clk); byte_tick = 1'b0;
  endtask

  task automatic pulse_index();
    @(negedge clk); index_in = 1'b1;
    @(negedge clk); index_in = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input string req);
    wr(b);
    chk(drq == 1'b0, "R8 drq after write", drq, 0);
    tick();
    if (b == 8'hF5) begin
      chk(out_valid && out_byte == 8'hA1 && out_mark, req, {out_valid, out_mark, out_byte}, 12'h3A1);
      mcrc = mstep(mstep(mstep(16'hFFFF, 8'hA1), 8'hA1), 8'hA1);
    end else if (b == 8'hF7) begin
      chk(out_valid && out_byte == mcrc[15:8] && !out_mark, "R6 R7 crc high", out_byte, mcrc[15:8]);
      wr(8'h4E);
      tick();
      chk(out_valid && out_byte == mcrc[7:0], "R6 R7 crc low", out_byte, mcrc[7:0]);
      chk(drq == 1'b0, "R6 second crc slot consumed no byte", drq, 0);
      tick();
      chk(out_byte == 8'h4E, "R6 held byte follows crc", out_byte, 8'h4E);
      mcrc = mstep(mcrc, 8'h4E);
    end else begin
      chk(out_valid && out_byte == b && !out_mark, req, out_byte, b);
      mcrc = mstep(mcrc, b);
    end
    chk(drq == 1'b1, "R8 drq after consume", drq, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!busy && !drq && !lost && !out_valid, "R1 reset state", {busy, drq, lost, out_valid}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_start();
    wr(8'h55);
    chk(!busy && !drq, "R2 idle write ignored", {busy, drq}, 0);
    do_start();
    chk(busy && drq, "R2 start raises busy drq", {busy, drq}, 3);
    do_start();
    chk(busy && drq, "R2 start while busy ignored", {busy, drq}, 3);
    wr(8'h4E);
    tick();
    chk(!out_valid, "R3 no output before index", out_valid, 0);
    chk(!drq, "R3 byte kept before index", drq, 0);
  endtask

  task automatic t_id_field();
    pulse_index();
    mcrc = 16'hFFFF;
    tick();
    chk(out_valid && out_byte == 8'h4E && !out_mark, "R3 R4 first byte after index", out_byte, 8'h4E);
    send(8'h4E, "R4 gap byte");
    send(8'h00, "R4 zero byte");
    for (int i = 0; i < 3; i++) send(8'hF5, "R5 sync byte");
    send(8'hFE, "R7 id mark");
    send(8'h05, "R4 track");
    send(8'h00, "R4 side");
    send(8'h09, "R4 sector");
    send(8'h01, "R4 length code");
    send(8'hF7, "R6");
  endtask

  task automatic t_data_field(input logic [7:0] dam);
    for (int i = 0; i < 3; i++) send(8'hF5, "R5 sync byte");
    send(dam, "R7 data mark");
    for (int i = 0; i < 6; i++) send(8'(8'h30 + i * 7), "R4 data byte");
    send(8'hF7, "R6");
  endtask

  task automatic t_lost();
    chk(!lost, "R9 lost clear before underrun", lost, 0);
    tick();
    chk(out_valid && out_byte == 8'h00 && !out_mark, "R9 underrun emits 00", out_byte, 0);
    chk(lost, "R9 lost set", lost, 1);
    send(8'h4E, "R4 byte after underrun");
    chk(lost, "R9 lost sticky", lost, 1);
  endtask

  task automatic t_end();
    pulse_index();
    chk(!busy && !drq, "R10 second index ends", {busy, drq}, 0);
    tick();
    chk(!out_valid, "R10 no output after end", out_valid, 0);
    chk(lost, "R9 lost held after end", lost, 1);
    do_start();
    chk(!lost && busy, "R9 R2 start clears lost", {lost, busy}, 1);
    pulse_index();
    mcrc = 16'hFFFF;
    t_data_field(8'hF8);
    pulse_index();
    chk(!busy, "R10 second command ends", busy, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_start();
        t_id_field();
        t_data_field(8'hFB);
        t_lost();
        t_end();
      end
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule